// File: doc/BRIEF.md
# Three-Dimensional Transfer Address Generator

This block turns one loaded parameter set into a sequence of row requests for a data mover. A transfer is a cube of bytes: a row is a run of `acnt` bytes, a frame is `bcnt` rows, and the whole transfer is `ccnt` frames. Each row goes out on a valid/ready request stream as one beat carrying the source start address, the destination start address and the row length. The mover that consumes the stream does the bus work. The generator only walks the addresses.

Rows are released by a sync trigger. In row-sync mode, a trigger releases one row. In frame-sync mode, a trigger releases every remaining row of the current frame. Either side can be pinned to a fixed address, as for a peripheral FIFO. In that case the request also carries the per-access width for that side. The current addresses and remaining counts are always visible on writeback outputs. A one-cycle completion pulse marks the end of the transfer.

The request stream follows the usual back-pressure rules. Once `req_valid` is high, it stays high, and every `req_*` field stays unchanged, until a cycle with `req_ready` high. A beat is consumed on any clock edge where both signals are high. `req_valid` never depends on `req_ready`.

Top module: `xfer3d_agen`

## Requirements
- R1: After reset, `req_valid`, `done` and `busy` are 0, and `wb_bcnt` and `wb_ccnt` are 0.
- R2: A `load` pulse while `busy` is 0 captures all parameter inputs, and `busy` is 1 from the next cycle. A `load` while `busy` is 1 is ignored, and the running transfer continues with its original parameters.
- R3: With `opt[2]`=1 (frame sync), one trigger releases every remaining row of the current frame. Row k of a frame starts at the frame start plus k times the side's B index.
- R4: With `opt[2]`=0 (row sync), one trigger releases exactly one row, and `req_valid` drops after that row is taken. The next row starts at the previous row's last byte (start + `acnt` - 1) plus the side's B index.
- R5: After the last row of a frame, the next frame starts at the C index added to one of two addresses. In frame sync that address is the start of the previous frame's first row. In row sync it is the start of the previous frame's last row.
- R6: `opt[0]`=1 holds the source address at `src_base`, and `opt[1]`=1 holds the destination address at `dst_base`, for the whole transfer. These flags appear on `req_src_hold` and `req_dst_hold`. `req_beat_bytes` = 1 << `opt[10:8]`.
- R7: B and C indexes are signed 16-bit two's-complement values. All address arithmetic wraps modulo 2^32.
- R8: While `req_valid` is 1 and `req_ready` is 0, `req_valid` stays 1 and `req_src`, `req_dst` and `req_len` stay unchanged.
- R9: A trigger is ignored while no transfer is loaded, and also while released rows are still waiting to be taken.
- R10: `done` is high for exactly one cycle, in the cycle after the handshake of the last row of the last frame. `busy` falls in that same cycle.
- R11: `wb_src` and `wb_dst` show the current row start addresses. `wb_bcnt` shows the rows left in the current frame, including the current row. `wb_ccnt` shows the frames left. Both counts read 0 after completion.
- R12: A `load` with `acnt`, `bcnt` or `ccnt` equal to 0 issues no request. It gives a `done` pulse in the next cycle, and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture the parameter set |
| opt | input | 32 | Options: bit0 source hold, bit1 destination hold, bit2 frame sync, bits10:8 access-width code |
| src_base | input | 32 | Source start address |
| dst_base | input | 32 | Destination start address |
| acnt | input | 16 | Bytes per row |
| bcnt | input | 16 | Rows per frame |
| ccnt | input | 16 | Frames per transfer |
| src_bidx | input | 16 | Signed source row index |
| dst_bidx | input | 16 | Signed destination row index |
| src_cidx | input | 16 | Signed source frame index |
| dst_cidx | input | 16 | Signed destination frame index |
| trig | input | 1 | Sync trigger |
| req_valid | output | 1 | Row request valid |
| req_ready | input | 1 | Consumer accepts the row request |
| req_src | output | 32 | Row source start address |
| req_dst | output | 32 | Row destination start address |
| req_len | output | 16 | Row length in bytes |
| req_src_hold | output | 1 | Source address is fixed |
| req_dst_hold | output | 1 | Destination address is fixed |
| req_beat_bytes | output | 8 | Access width for a fixed side |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transfer loaded and not finished |
| wb_src | output | 32 | Current source row address |
| wb_dst | output | 32 | Current destination row address |
| wb_bcnt | output | 16 | Rows left in the current frame |
| wb_ccnt | output | 16 | Frames left |

## Verification
The hardest state to reach from the ports is a trigger, or a second load, that arrives while a released row is held back by the consumer. Neither one may change what comes out of the stream. The stimulus gets there with a row-sync transfer whose row is stalled by holding `req_ready` low. During the stall it pulses both `trig` and `load` with different parameters. It then lets the row go and confirms that no extra row appears and that the second row still follows the original parameters. Frame boundaries in both sync modes, negative indexes that wrap below zero, and zero-count loads are driven through dedicated transfers whose expected addresses the bench works out itself.

// File: rtl/xfer3d_pkg.sv
package xfer3d_pkg;
  typedef enum logic {
    SYNC_ROW   = 1'b0,
    SYNC_FRAME = 1'b1
  } sync_mode_e;

  localparam int OPT_SRC_HOLD = 0;
  localparam int OPT_DST_HOLD = 1;
  localparam int OPT_SYNC     = 2;
  localparam int OPT_WID_LO   = 8;
  localparam int OPT_WID_HI   = 10;
endpackage

// File: rtl/xfer3d_side.sv
module xfer3d_side
  import xfer3d_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] base,
  input  logic [IW-1:0] bidx,
  input  logic [IW-1:0] cidx,
  input  logic          hold,
  input  sync_mode_e    mode,
  input  logic [CW-1:0] acnt_q,
  input  logic          busy,
  input  logic          step_row,
  input  logic          step_frame,
  output logic [AW-1:0] cur,
  output logic          hold_q
);
  localparam int XW = AW - IW;

  logic [AW-1:0] cur_q, frm_q;
  logic [IW-1:0] bidx_q, cidx_q;
  logic [AW-1:0] b_ext, c_ext, a_ext, row_nxt, frm_nxt;

  assign b_ext = {{XW{bidx_q[IW-1]}}, bidx_q};
  assign c_ext = {{XW{cidx_q[IW-1]}}, cidx_q};
  assign a_ext = {{(AW-CW){1'b0}}, acnt_q};

  always_comb begin
    if (hold_q) begin
      row_nxt = cur_q;
      frm_nxt = cur_q;
    end else if (mode == SYNC_FRAME) begin
      row_nxt = cur_q + b_ext;
      frm_nxt = frm_q + c_ext;
    end else begin
      row_nxt = cur_q + a_ext - {{(AW-1){1'b0}}, 1'b1} + b_ext;
      frm_nxt = cur_q + c_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      frm_q  <= '0;
      bidx_q <= '0;
      cidx_q <= '0;
      hold_q <= 1'b0;
    end else if (ld) begin
      cur_q  <= base;
      frm_q  <= base;
      bidx_q <= bidx;
      cidx_q <= cidx;
      hold_q <= hold;
    end else if (step_frame) begin
      cur_q <= frm_nxt;
      frm_q <= frm_nxt;
    end else if (step_row) begin
      cur_q <= row_nxt;
    end
  end

  assign cur = cur_q;

  // R6: a held side never moves while a transfer runs
  a_r6_hold_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && hold_q |-> $stable(cur_q));
endmodule

// File: rtl/xfer3d_ctrl.sv
module xfer3d_ctrl
  import xfer3d_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          mode_in,
  input  logic [CW-1:0] acnt,
  input  logic [CW-1:0] bcnt,
  input  logic [CW-1:0] ccnt,
  input  logic          trig,
  input  logic          req_ready,
  output logic          ld,
  output logic          req_valid,
  output logic          step_row,
  output logic          step_frame,
  output sync_mode_e    mode_q,
  output logic [CW-1:0] acnt_q,
  output logic [CW-1:0] bleft,
  output logic [CW-1:0] cleft,
  output logic          busy,
  output logic          done
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] bcnt_q;
  logic          pend, fire, is_null;

  assign ld         = load && !busy;
  assign is_null    = (acnt == '0) || (bcnt == '0) || (ccnt == '0);
  assign fire       = pend && req_ready;
  assign step_row   = fire && (bleft > ONE);
  assign step_frame = fire && (bleft == ONE) && (cleft > ONE);
  assign req_valid  = pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      pend   <= 1'b0;
      done   <= 1'b0;
      mode_q <= SYNC_ROW;
      acnt_q <= '0;
      bcnt_q <= '0;
      bleft  <= '0;
      cleft  <= '0;
    end else begin
      done <= 1'b0;
      if (ld) begin
        mode_q <= sync_mode_e'(mode_in);
        acnt_q <= acnt;
        bcnt_q <= bcnt;
        pend   <= 1'b0;
        if (is_null) begin
          done  <= 1'b1;
          bleft <= '0;
          cleft <= '0;
        end else begin
          busy  <= 1'b1;
          bleft <= bcnt;
          cleft <= ccnt;
        end
      end else if (busy) begin
        if (trig && !pend) pend <= 1'b1;
        if (fire) begin
          if (bleft > ONE) begin
            bleft <= bleft - ONE;
            if (mode_q == SYNC_ROW) pend <= 1'b0;
          end else if (cleft > ONE) begin
            cleft <= cleft - ONE;
            bleft <= bcnt_q;
            pend  <= 1'b0;
          end else begin
            bleft <= '0;
            cleft <= '0;
            pend  <= 1'b0;
            busy  <= 1'b0;
            done  <= 1'b1;
          end
        end
      end
    end
  end

  // R8: a stalled request stays offered
  a_r8_stall_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid);
  // R4: in row sync a taken row is not followed at once by another
  a_r4_one_row: assert property (@(posedge clk) disable iff (!rst_n)
    fire && mode_q == SYNC_ROW |=> !req_valid);
  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11: rows left never exceed the loaded row count
  a_r11_bleft_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bleft <= bcnt_q && bleft != '0);
endmodule

// File: rtl/xfer3d_agen.sv
module xfer3d_agen
  import xfer3d_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int IW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [31:0]   opt,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [CW-1:0] acnt,
  input  logic [CW-1:0] bcnt,
  input  logic [CW-1:0] ccnt,
  input  logic [IW-1:0] src_bidx,
  input  logic [IW-1:0] dst_bidx,
  input  logic [IW-1:0] src_cidx,
  input  logic [IW-1:0] dst_cidx,
  input  logic          trig,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_src,
  output logic [AW-1:0] req_dst,
  output logic [CW-1:0] req_len,
  output logic          req_src_hold,
  output logic          req_dst_hold,
  output logic [BW-1:0] req_beat_bytes,
  output logic          done,
  output logic          busy,
  output logic [AW-1:0] wb_src,
  output logic [AW-1:0] wb_dst,
  output logic [CW-1:0] wb_bcnt,
  output logic [CW-1:0] wb_ccnt
);
  localparam int NSIDE = 2;

  logic          ld, step_row, step_frame;
  sync_mode_e    mode_q;
  logic [CW-1:0] acnt_q;
  logic [BW-1:0] beat_q;

  logic [AW-1:0] base_a [NSIDE];
  logic [IW-1:0] bidx_a [NSIDE];
  logic [IW-1:0] cidx_a [NSIDE];
  logic          hold_a [NSIDE];
  logic [AW-1:0] cur_a  [NSIDE];
  logic          hq_a   [NSIDE];

  assign base_a[0] = src_base;
  assign base_a[1] = dst_base;
  assign bidx_a[0] = src_bidx;
  assign bidx_a[1] = dst_bidx;
  assign cidx_a[0] = src_cidx;
  assign cidx_a[1] = dst_cidx;
  assign hold_a[0] = opt[OPT_SRC_HOLD];
  assign hold_a[1] = opt[OPT_DST_HOLD];

  xfer3d_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(load), .mode_in(opt[OPT_SYNC]),
    .acnt(acnt), .bcnt(bcnt), .ccnt(ccnt), .trig(trig),
    .req_ready(req_ready), .ld(ld), .req_valid(req_valid),
    .step_row(step_row), .step_frame(step_frame), .mode_q(mode_q),
    .acnt_q(acnt_q), .bleft(wb_bcnt), .cleft(wb_ccnt),
    .busy(busy), .done(done)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    xfer3d_side #(.AW(AW), .CW(CW), .IW(IW)) u_side (
      .clk(clk), .rst_n(rst_n), .ld(ld), .base(base_a[s]),
      .bidx(bidx_a[s]), .cidx(cidx_a[s]), .hold(hold_a[s]),
      .mode(mode_q), .acnt_q(acnt_q), .busy(busy),
      .step_row(step_row), .step_frame(step_frame),
      .cur(cur_a[s]), .hold_q(hq_a[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  beat_q <= '0;
    else if (ld) beat_q <= BW'(1) << opt[OPT_WID_HI:OPT_WID_LO];
  end

  assign req_src        = cur_a[0];
  assign req_dst        = cur_a[1];
  assign req_len        = acnt_q;
  assign req_src_hold   = hq_a[0];
  assign req_dst_hold   = hq_a[1];
  assign req_beat_bytes = beat_q;
  assign wb_src         = cur_a[0];
  assign wb_dst         = cur_a[1];

  // R8: stalled request fields do not move
  a_r8_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> $stable(req_src) && $stable(req_dst) && $stable(req_len));
  // R10: completion only while a transfer is present or on a null load
  a_r10_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy) || $past(load));
endmodule

// File: tb/sim_xfer3d_agen.sv
module sim_xfer3d_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [31:0] opt = '0;
  logic [31:0] src_base = '0, dst_base = '0;
  logic [15:0] acnt = '0, bcnt = '0, ccnt = '0;
  logic [15:0] src_bidx = '0, dst_bidx = '0, src_cidx = '0, dst_cidx = '0;
  logic        trig = 1'b0;
  logic        req_ready = 1'b1;
  logic        req_valid, req_src_hold, req_dst_hold, done, busy;
  logic [31:0] req_src, req_dst, wb_src, wb_dst;
  logic [15:0] req_len, wb_bcnt, wb_ccnt;
  logic [7:0]  req_beat_bytes;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  xfer3d_agen u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .opt(opt),
    .src_base(src_base), .dst_base(dst_base), .acnt(acnt), .bcnt(bcnt),
    .ccnt(ccnt), .src_bidx(src_bidx), .dst_bidx(dst_bidx),
    .src_cidx(src_cidx), .dst_cidx(dst_cidx), .trig(trig),
    .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
    .req_dst(req_dst), .req_len(req_len), .req_src_hold(req_src_hold),
    .req_dst_hold(req_dst_hold), .req_beat_bytes(req_beat_bytes),
    .done(done), .busy(busy), .wb_src(wb_src), .wb_dst(wb_dst),
    .wb_bcnt(wb_bcnt), .wb_ccnt(wb_ccnt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_load(input logic [31:0] o, sb, db, input logic [15:0] a, b, c,
                         input logic [15:0] sbi, dbi, sci, dci);
    opt = o; src_base = sb; dst_base = db; acnt = a; bcnt = b; ccnt = c;
    src_bidx = sbi; dst_bidx = dbi; src_cidx = sci; dst_cidx = dci;
    load = 1'b1;
    tick();
    load = 1'b0;
  endtask

  task automatic pulse_trig();
    trig = 1'b1;
    tick();
    trig = 1'b0;
  endtask

  task automatic wait_valid(input string req);
    int n = 0;
    while (!req_valid && n < 20) begin
      tick();
      n++;
    end
    chk(req_valid, req, "row request not offered", 64'(req_valid), 64'd1);
  endtask

  // Runs a whole transfer with req_ready high and checks every row
  task automatic run_xfer(input logic [31:0] o, sb, db, input logic [15:0] a, b, c,
                          input logic [15:0] sbi, dbi, sci, dci, input string req);
    logic [31:0] es, ed, fs, fd, sx, dx, scx, dcx;
    bit ab = o[2];
    sx = {{16{sbi[15]}}, sbi};  dx = {{16{dbi[15]}}, dbi};
    scx = {{16{sci[15]}}, sci}; dcx = {{16{dci[15]}}, dci};
    es = sb; ed = db; fs = sb; fd = db;
    req_ready = 1'b1;
    do_load(o, sb, db, a, b, c, sbi, dbi, sci, dci);
    chk(busy == 1'b1, "R2", "busy after load", 64'(busy), 64'd1);
    chk(wb_bcnt == b && wb_ccnt == c, "R11", "counts after load",
        {wb_bcnt, wb_ccnt}, {b, c});
    for (int ci = 0; ci < c; ci++) begin
      if (ab) pulse_trig();
      for (int bi = 0; bi < b; bi++) begin
        if (!ab) pulse_trig();
        wait_valid(req);
        chk(req_src == es, req, "row source", req_src, es);
        chk(req_dst == ed, req, "row destination", req_dst, ed);
        chk(req_len == a, req, "row length", req_len, a);
        tick();
        if (!ab && !(ci == c - 1 && bi == b - 1))
          chk(!req_valid, "R4", "valid after one row", 64'(req_valid), 64'd0);
        if (bi < b - 1) begin
          if (!o[0]) es = ab ? es + sx : es + a - 1 + sx;
          if (!o[1]) ed = ab ? ed + dx : ed + a - 1 + dx;
        end else if (ci < c - 1) begin
          if (!o[0]) es = ab ? fs + scx : es + scx;
          if (!o[1]) ed = ab ? fd + dcx : ed + dcx;
          fs = es; fd = ed;
        end
      end
    end
    chk(done == 1'b1 && busy == 1'b0, "R10", "done/busy after last row",
        {done, busy}, 2'b10);
    chk(wb_bcnt == 0 && wb_ccnt == 0, "R11", "counts after done",
        {wb_bcnt, wb_ccnt}, 0);
    chk(wb_src == es && wb_dst == ed, "R11", "writeback addresses",
        {wb_src, wb_dst}, {es, ed});
    tick();
    chk(done == 1'b0, "R10", "done is one cycle", 64'(done), 64'd0);
  endtask

  task automatic t_reset();
    chk(!req_valid && !done && !busy, "R1", "outputs in reset",
        {req_valid, done, busy}, 0);
    chk(wb_bcnt == 0 && wb_ccnt == 0, "R1", "counts in reset",
        {wb_bcnt, wb_ccnt}, 0);
  endtask

  task automatic t_frame_sync();
    run_xfer(32'h4, 32'h1000, 32'h8000, 16'd8, 16'd3, 16'd2,
             16'd16, 16'd32, 16'h100, 16'h200, "R3");
    run_xfer(32'h4, 32'h40, 32'h80, 16'd2, 16'd2, 16'd3,
             16'd4, 16'd4, 16'h10, 16'h20, "R5");
  endtask

  task automatic t_row_sync();
    run_xfer(32'h0, 32'h2000, 32'h3000, 16'd4, 16'd2, 16'd2,
             16'd4, 16'd8, 16'd64, 16'hFFF0, "R4");
    run_xfer(32'h0, 32'h100, 32'h200, 16'd1, 16'd3, 16'd2,
             16'd1, 16'd2, 16'd3, 16'd5, "R5");
  endtask

  task automatic t_hold();
    do_load(32'h305, 32'hA000, 32'hB000, 16'd4, 16'd2, 16'd1,
            16'd4, 16'd4, 16'd0, 16'd0);
    chk(req_src_hold && !req_dst_hold, "R6", "hold flags",
        {req_src_hold, req_dst_hold}, 2'b10);
    chk(req_beat_bytes == 8'd8, "R6", "beat bytes", req_beat_bytes, 8'd8);
    pulse_trig();
    tick();
    chk(req_src == 32'hA000 && req_dst == 32'hB004, "R6", "second row",
        {req_src, req_dst}, {32'hA000, 32'hB004});
    tick();
    run_xfer(32'h002, 32'h500, 32'h600, 16'd4, 16'd2, 16'd2,
             16'd4, 16'd4, 16'd16, 16'd16, "R6");
  endtask

  task automatic t_wrap();
    run_xfer(32'h4, 32'h10, 32'hFFFF_FFF8, 16'd4, 16'd2, 16'd2,
             16'hFFE0, 16'd16, 16'hFF00, 16'h0100, "R7");
  endtask

  task automatic t_stall();
    logic [31:0] s0, d0;
    req_ready = 1'b0;
    do_load(32'h0, 32'h200, 32'h300, 16'd4, 16'd2, 16'd1,
            16'd0, 16'd4, 16'd0, 16'd0);
    pulse_trig();
    chk(req_valid, "R8", "row offered", 64'(req_valid), 64'd1);
    s0 = req_src; d0 = req_dst;
    trig = 1'b1;
    load = 1'b1; src_base = 32'hDEAD0000; opt = 32'h4;
    tick();
    trig = 1'b0; load = 1'b0;
    tick();
    chk(req_valid && req_src == s0 && req_dst == d0 && req_len == 16'd4, "R8",
        "stalled fields", {req_src, req_dst}, {s0, d0});
    req_ready = 1'b1;
    tick();
    for (int i = 0; i < 3; i++) begin
      chk(!req_valid, "R9", "no extra row from stalled trigger", 64'(req_valid), 64'd0);
      tick();
    end
    pulse_trig();
    chk(req_valid && req_src == 32'h203 && req_dst == 32'h307, "R2",
        "row after ignored load", {req_src, req_dst}, {32'h203, 32'h307});
    tick();
    chk(done && !busy, "R10", "done after stalled transfer", {done, busy}, 2'b10);
    tick();
  endtask

  task automatic t_idle_and_null();
    pulse_trig();
    tick();
    chk(!req_valid && !busy, "R9", "trigger while idle", {req_valid, busy}, 0);
    do_load(32'h4, 32'h0, 32'h0, 16'd4, 16'd2, 16'd0,
            16'd0, 16'd0, 16'd0, 16'd0);
    chk(done && !busy && !req_valid, "R12", "zero frame count",
        {done, busy, req_valid}, 3'b100);
    pulse_trig();
    chk(!req_valid && !done, "R12", "no row after null", {req_valid, done}, 0);
    do_load(32'h0, 32'h0, 32'h0, 16'd4, 16'd0, 16'd3,
            16'd0, 16'd0, 16'd0, 16'd0);
    chk(done && !busy, "R12", "zero row count", {done, busy}, 2'b10);
    tick();
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_frame_sync();
    t_row_sync();
    t_hold();
    t_wrap();
    t_stall();
    t_idle_and_null();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule